// File: doc/BRIEF.md
# DMA Stream Bus Arbiter

This block picks, every bus beat, which of eight DMA streams may drive the shared system bus, or whether the beat goes to the CPU master instead. Each stream carries a two-bit priority that software programs. Among the streams that are requesting, the highest programmed level wins. When several requesters share that level, the lowest stream index wins. A stream may use its source or destination port only in a beat where it holds the grant.

The CPU competes for the same bus. A single state bit records whether the previous beat went to a DMA stream. If the CPU requests right after a DMA beat, it takes the next beat. Under contention, DMA and CPU beats therefore alternate, and the CPU never waits more than one beat. It keeps at least half of the contended bandwidth. When the CPU is silent, streams may hold the bus on every beat. Grants are combinational from the current requests and that one state bit, and the arbitration is repeated every cycle.

Top module: `dma_stream_arbiter`

## Requirements
- R1: After reset the history bit is clear, so the first beat in which the CPU and a stream both request goes to the stream. This holds also after a reset that interrupts a run.
- R2: The grant vector {cpu_gnt, stream_gnt} has at most one bit set in every cycle.
- R3: stream_gnt[i] is set only while stream_req[i] is set. cpu_gnt is set only while cpu_req is set.
- R4: Stream i's priority is stream_prio[2i+1:2i], with 3 as the highest level and 0 as the lowest. The granted stream has the highest level among the requesting streams.
- R5: Among the requesting streams at the winning level, the lowest index is granted.
- R6: If any stream was granted in the previous cycle and cpu_req is high now, cpu_gnt is set and no stream is granted.
- R7: With cpu_req high and no stream requesting, cpu_gnt is set.
- R8: With cpu_req low and at least one stream requesting, a stream is granted in every cycle, including consecutive cycles.
- R9: With no request of any kind, no grant is set.
- R10: A CPU request that is refused in one cycle and still present in the next cycle is granted in that next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stream_req | input | 8 | Request line of each stream |
| stream_prio | input | 16 | Two-bit software priority per stream, stream i at bits 2i+1:2i |
| cpu_req | input | 1 | CPU master wants the bus this beat |
| stream_gnt | output | 8 | One-hot stream grant, or zero |
| cpu_gnt | output | 1 | CPU grant |

## Verification
Priority selection is tried with distinct levels on scattered streams, which separates level ordering from index ordering. It is also tried with all streams at one level, and with ties only at the top level, which isolates the index tie-break. CPU sharing is tried with sustained contention, which must alternate, and with the CPU alone, which must be granted. Streams alone must hold the bus continuously, which distinguishes a fairness rule that only applies under contention from one that idles the bus. A pseudo-random run, compared beat by beat against a behavioural model, mixes all of these. Resets in mid-run confirm that the history bit is cleared.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned STREAMS_DEF = 8;
  localparam int unsigned PRIO_W_DEF  = 2;

  typedef enum logic {
    LAST_OTHER = 1'b0,
    LAST_DMA   = 1'b1
  } last_owner_e;
endpackage

// File: rtl/dma_arb_level_mask.sv
// Keeps only the requesters that sit at the highest programmed level present.
module dma_arb_level_mask #(
  parameter int unsigned N      = 8,
  parameter int unsigned PRIO_W = 2
) (
  input  logic [N-1:0]        req,
  input  logic [N*PRIO_W-1:0] prio,
  output logic [N-1:0]        top_mask
);
  localparam int unsigned NL = 1 << PRIO_W;

  logic [N-1:0]  on_level [NL];
  logic [NL-1:0] level_hit;

  for (genvar l = 0; l < NL; l++) begin : g_level
    for (genvar s = 0; s < N; s++) begin : g_stream
      assign on_level[l][s] = (prio[s*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
    assign level_hit[l] = |(req & on_level[l]);
  end

  logic [PRIO_W-1:0] top_level;

  always_comb begin
    top_level = '0;
    for (int l = 0; l < NL; l++) begin
      if (level_hit[l]) top_level = PRIO_W'(l);
    end
  end

  assign top_mask = req & on_level[top_level];
endmodule

// File: rtl/dma_arb_first_pick.sv
// Fixed tie-break: lowest set index wins.
module dma_arb_first_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] pick
);
  assign pick = cand & (~cand + N'(1));
endmodule

// File: rtl/dma_arb_share_gate.sv
// Holds the one-bit history and decides whether the CPU owns this beat.
module dma_arb_share_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic dma_pending,
  input  logic dma_granted,
  output logic cpu_turn
);
  import dma_arb_pkg::*;

  last_owner_e last_q, last_d;
  logic        last_en;

  always_comb begin
    last_d  = dma_granted ? LAST_DMA : LAST_OTHER;
    last_en = (last_d != last_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LAST_OTHER;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  assign cpu_turn = cpu_req & ((last_q == LAST_DMA) | ~dma_pending);
endmodule

// File: rtl/dma_stream_arbiter.sv
module dma_stream_arbiter #(
  parameter int unsigned N_STREAMS = dma_arb_pkg::STREAMS_DEF,
  parameter int unsigned PRIO_W    = dma_arb_pkg::PRIO_W_DEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_STREAMS-1:0]        stream_req,
  input  logic [N_STREAMS*PRIO_W-1:0] stream_prio,
  input  logic                        cpu_req,
  output logic [N_STREAMS-1:0]        stream_gnt,
  output logic                        cpu_gnt
);
  logic [N_STREAMS-1:0] top_mask;
  logic [N_STREAMS-1:0] winner;
  logic                 cpu_turn;
  logic                 dma_pending;

  assign dma_pending = |stream_req;

  dma_arb_level_mask #(.N(N_STREAMS), .PRIO_W(PRIO_W)) u_level (
    .req      (stream_req),
    .prio     (stream_prio),
    .top_mask (top_mask)
  );

  dma_arb_first_pick #(.N(N_STREAMS)) u_pick (
    .cand (top_mask),
    .pick (winner)
  );

  dma_arb_share_gate u_share (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .dma_pending (dma_pending),
    .dma_granted (|stream_gnt),
    .cpu_turn    (cpu_turn)
  );

  assign stream_gnt = cpu_turn ? '0 : winner;
  assign cpu_gnt    = cpu_turn;
endmodule

// File: rtl/dma_stream_arbiter_chk.sv
module dma_stream_arbiter_chk #(
  parameter int unsigned N      = 8,
  parameter int unsigned PRIO_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         stream_req,
  input logic [N*PRIO_W-1:0]  stream_prio,
  input logic                 cpu_req,
  input logic [N-1:0]         stream_gnt,
  input logic                 cpu_gnt
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic order_bad;
  always_comb begin
    order_bad = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (stream_gnt[i] && stream_req[j] &&
            ((stream_prio[j*PRIO_W +: PRIO_W] > stream_prio[i*PRIO_W +: PRIO_W]) ||
             ((stream_prio[j*PRIO_W +: PRIO_W] == stream_prio[i*PRIO_W +: PRIO_W]) && (j < i))))
          order_bad = 1'b1;
      end
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, stream_gnt}));

  assert_gnt_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stream_gnt & ~stream_req) == '0) && (!cpu_gnt || cpu_req));

  assert_order_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !order_bad);

  assert_cpu_after_dma_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(|stream_gnt) && cpu_req) |-> (cpu_gnt && stream_gnt == '0));

  assert_no_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && |stream_req) |-> $onehot(stream_gnt));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && stream_req == '0) |-> (!cpu_gnt && stream_gnt == '0));

  assert_cpu_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_gnt) |=> (!cpu_req || cpu_gnt));
endmodule

bind dma_stream_arbiter dma_stream_arbiter_chk #(.N(N_STREAMS), .PRIO_W(PRIO_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stream_req  (stream_req),
  .stream_prio (stream_prio),
  .cpu_req     (cpu_req),
  .stream_gnt  (stream_gnt),
  .cpu_gnt     (cpu_gnt)
);

// File: tb/dma_stream_arbiter_tb.sv
module dma_stream_arbiter_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  stream_req;
  logic [15:0] stream_prio;
  logic        cpu_req;
  logic [7:0]  stream_gnt;
  logic        cpu_gnt;

  int checks = 0;
  int fails  = 0;
  bit model_last_dma;
  bit done = 0;

  dma_stream_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .stream_req(stream_req), .stream_prio(stream_prio),
    .cpu_req(cpu_req), .stream_gnt(stream_gnt), .cpu_gnt(cpu_gnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference: highest level first, then lowest index; CPU takes the beat after a DMA beat.
  function automatic logic [8:0] expect_grant(logic [7:0] rq, logic [15:0] pr, logic cr, bit last);
    logic [8:0] r;
    int win;
    r = '0;
    win = -1;
    for (int lvl = 3; lvl >= 0 && win < 0; lvl--)
      for (int s = 0; s < 8 && win < 0; s++)
        if (rq[s] && int'((pr >> (2*s)) & 16'h3) == lvl) win = s;
    if (cr && (last || win < 0)) r[8] = 1'b1;
    else if (win >= 0) r[win] = 1'b1;
    return r;
  endfunction

  task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got cpu=%b streams=%b, expected cpu=%b streams=%b",
               tag, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic step(string tag, logic [7:0] rq, logic [15:0] pr, logic cr);
    logic [8:0] e;
    @(negedge clk);
    stream_req = rq; stream_prio = pr; cpu_req = cr;
    #5;
    e = expect_grant(rq, pr, cr, model_last_dma);
    check(tag, {cpu_gnt, stream_gnt}, e);
    model_last_dma = |e[7:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    stream_req = '0; stream_prio = '0; cpu_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_last_dma = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; stream_req = '0; stream_prio = '0; cpu_req = 1'b0;
    model_last_dma = 1'b0;
    do_reset();

    // R9: idle after reset
    step("R9 idle", 8'h00, 16'h0000, 1'b0);
    // R1: first contended beat after reset goes to a stream
    step("R1 first contention", 8'h10, 16'h0000, 1'b1);
    step("R6 cpu after dma", 8'h10, 16'h0000, 1'b1);
    // R4: distinct levels, highest level on a high index
    step("R4 levels", 8'b1010_0101, 16'b11_00_01_00_00_10_00_01, 1'b0);
    step("R4 levels b", 8'b0000_0111, 16'b00_00_00_00_00_01_11_10, 1'b0);
    // R5: all at one level, then ties only at top level
    step("R5 tie all", 8'b1111_1110, 16'hAAAA, 1'b0);
    step("R5 tie top", 8'b1001_0010, 16'b11_00_00_11_00_00_01_00, 1'b0);
    // R8: streams alone hold consecutive beats
    for (int k = 0; k < 4; k++) step("R8 no idle", 8'h80, 16'h0000, 1'b0);
    // R6/R10: sustained contention alternates
    for (int k = 0; k < 6; k++) step("R6 R10 alternate", 8'h03, 16'h0005, 1'b1);
    // R7: CPU alone
    for (int k = 0; k < 3; k++) step("R7 cpu alone", 8'h00, 16'hFFFF, 1'b1);
    // R1: reset interrupting a DMA run clears the history
    step("R1 pre-reset dma", 8'h04, 16'h0000, 1'b0);
    do_reset();
    step("R1 after mid reset", 8'h04, 16'h0000, 1'b1);
    step("R6 after mid reset", 8'h04, 16'h0000, 1'b1);

    // R2 R3 R4 R5 R6: pseudo-random mix against the model
    lfsr = 32'hACE1_2357;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R2 R3 R4 R5 R6 random", lfsr[7:0] & lfsr[15:8], lfsr[31:16], lfsr[3] | lfsr[9]);
    end
    step("R9 final idle", 8'h00, 16'h0000, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule